// File: doc/BRIEF.md
# Chip-Enable Latched Byte Memory

This block is a clock-sampled model of a bytewide nonvolatile RAM that does not decode its address continuously. Instead, the address is captured at the sample where the active-low chip select is first seen low after being high. From that capture the block runs a fixed-length internal memory cycle. The cycle always runs to completion, even if the chip select is released early. A mandatory precharge interval follows before the next capture is allowed. The storage array is not cleared by reset, so its contents survive a reset of the control state.

A read cycle presents the stored byte once the access time has elapsed and the output enable is low. A write can be set up in two ways. In a select-timed write, the write strobe is already low at capture, and the data bus is never driven during that cycle. In a strobe-timed write, the cycle starts as a read and the write strobe falls later; the bus is released from that point on. In both styles the write ends at whichever of the strobe or the select is first seen high. The byte stored is the one present at the last sample with both low. The data bus is modelled as a separate write-data input, a read-data output and a drive-enable output.

Two misuse conditions raise a sticky timing-error flag: a select fall that arrives before the cycle and its precharge are over, and a select held low for longer than the maximum active time.

Top module: `cel_bytemem`

## Requirements
- R1: The address is captured at the first rising clock edge where `chip_sel_n` is sampled 0 after having been sampled 1. Later changes of `bus_addr` during that cycle have no effect. The byte location is selected by the low log2(DEPTH) bits of the captured address.
- R2: In a read cycle (`wr_en_n` high at capture, `chip_sel_n` 0, `out_en_n` 0), `rdat_oe` is 1 and `rdat` equals the stored byte from the T_ACC-th edge after the capture edge onward. Whenever `rdat_oe` is 0, `rdat` is 0.
- R3: If `wr_en_n` is 0 at the capture edge, `rdat_oe` stays 0 for the whole cycle, whatever `out_en_n` is.
- R4: If `wr_en_n` falls after capture, the bus is driven according to `out_en_n` until `wr_en_n` is 0. From then on it stays released until the cycle ends, even after `wr_en_n` returns to 1.
- R5: A write stores the `wdat` sampled at the last edge where both `chip_sel_n` and `wr_en_n` were 0. The store takes place at the first edge where either of them is sampled 1.
- R6: `rdat_oe` is 0 before the access time has elapsed, and 0 whenever `out_en_n` is 1.
- R7: Releasing `chip_sel_n` early does not shorten the internal cycle. A new capture is accepted only when the internal cycle has completed and `chip_sel_n` has been sampled 1 on T_PRE consecutive edges, starting with the edge that first sees it high.
- R8: A `chip_sel_n` fall that arrives before R7 allows a capture starts no cycle: the bus stays undriven. It sets `timing_err`, which then stays 1 until reset.
- R9: `timing_err` is set when `chip_sel_n` is sampled 0 on more than T_MAXACT consecutive edges of one cycle, counting the capture edge.
- R10: A synchronous reset clears `timing_err` and returns the sequencer to idle, leaving the stored bytes unchanged.
- R11: A new access may start right after a write once the minimum precharge is met, with no polling, and it observes the newly written byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset of the control state |
| chip_sel_n | input | 1 | Active-low select; its sampled fall captures the address |
| wr_en_n | input | 1 | Active-low write strobe |
| out_en_n | input | 1 | Active-low output enable |
| bus_addr | input | ADDR_W | Byte address, captured at the select fall |
| wdat | input | DATA_W | Write data |
| rdat | output | DATA_W | Read data, 0 while not driven |
| rdat_oe | output | 1 | High when the block drives the data bus |
| timing_err | output | 1 | Sticky flag for precharge or active-time misuse |

## Verification
The assertions assume that the access time is at least one clock and that the strobes are synchronous to the sampling clock, held steady for a whole period. The bench drives every input shortly after a rising edge and samples shortly after that. As a result, each level is seen by exactly one set of edges. Its stimulus keeps `chip_sel_n` high through reset. In normal operations it waits the full precharge before the next fall, and it breaks the precharge and active-time limits only in the dedicated violation cases.

// File: rtl/cel_pkg.sv
package cel_pkg;

    typedef enum logic [1:0] {
        CS_IDLE   = 2'd0,
        CS_ACTIVE = 2'd1,
        CS_FINISH = 2'd2,
        CS_PRECH  = 2'd3
    } cyc_state_e;

    typedef struct packed {
        logic running;   // capture done, select still low
        logic data_ok;   // access time has elapsed
        logic wr_mode;   // this cycle has turned into a write
    } cyc_flags_t;

    function automatic logic sel_fell(input logic prev_n, input logic now_n);
        return prev_n & ~now_n;
    endfunction

    function automatic int cnt_w(input int lim);
        return (lim < 2) ? 1 : $clog2(lim + 1);
    endfunction

endpackage

// File: rtl/cel_seq.sv
module cel_seq
    import cel_pkg::*;
#(
    parameter int ADDR_W   = 15,
    parameter int DATA_W   = 8,
    parameter int T_ACC    = 7,
    parameter int T_PRE    = 6,
    parameter int T_MAXACT = 1000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              chip_sel_n,
    input  logic              wr_en_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] wdat,
    output logic [ADDR_W-1:0] lat_addr,
    output cyc_flags_t        flags,
    output logic              wr_commit,
    output logic [DATA_W-1:0] wr_data,
    output logic              timing_err
);

    localparam int ACC_W = cnt_w(T_ACC);
    localparam int PRE_W = cnt_w(T_PRE);
    localparam int LOW_W = cnt_w(T_MAXACT);
    localparam logic [ACC_W-1:0] ACC_LIM = ACC_W'(T_ACC);
    localparam logic [PRE_W-1:0] PRE_LIM = PRE_W'(T_PRE);
    localparam logic [LOW_W-1:0] LOW_LIM = LOW_W'(T_MAXACT);
    localparam logic [ACC_W-1:0] ACC_ONE = ACC_W'(1);
    localparam logic [PRE_W-1:0] PRE_ONE = PRE_W'(1);
    localparam logic [LOW_W-1:0] LOW_ONE = LOW_W'(1);

    cyc_state_e       st;
    logic             sel_q;
    logic             wr_open;
    logic             wr_mode;
    logic [ACC_W-1:0] acc_cnt;
    logic [PRE_W-1:0] pre_cnt;
    logic [LOW_W-1:0] low_cnt;
    logic             fall;
    logic             accept;

    assign fall      = sel_fell(sel_q, chip_sel_n);
    assign accept    = (st == CS_IDLE) || (st == CS_PRECH && pre_cnt == PRE_LIM);
    assign wr_commit = (st == CS_ACTIVE) && wr_open && (chip_sel_n || wr_en_n);

    assign flags.running = (st == CS_ACTIVE);
    assign flags.data_ok = (acc_cnt == ACC_LIM);
    assign flags.wr_mode = wr_mode;

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= CS_IDLE;
            sel_q      <= 1'b1;
            wr_open    <= 1'b0;
            wr_mode    <= 1'b0;
            acc_cnt    <= '0;
            pre_cnt    <= '0;
            low_cnt    <= '0;
            lat_addr   <= '0;
            wr_data    <= '0;
            timing_err <= 1'b0;
        end else begin
            sel_q <= chip_sel_n;
            if (fall && !accept) begin
                timing_err <= 1'b1;
            end
            unique case (st)
                CS_IDLE, CS_PRECH: begin
                    if (fall && accept) begin
                        st       <= CS_ACTIVE;
                        lat_addr <= bus_addr;
                        acc_cnt  <= '0;
                        low_cnt  <= LOW_ONE;
                        wr_mode  <= ~wr_en_n;
                        wr_open  <= ~wr_en_n;
                        wr_data  <= wdat;
                    end else if (st == CS_PRECH && pre_cnt != PRE_LIM) begin
                        pre_cnt <= pre_cnt + PRE_ONE;
                    end
                end
                CS_ACTIVE: begin
                    if (acc_cnt != ACC_LIM) begin
                        acc_cnt <= acc_cnt + ACC_ONE;
                    end
                    if (chip_sel_n) begin
                        wr_open <= 1'b0;
                        pre_cnt <= PRE_ONE;
                        st      <= (acc_cnt == ACC_LIM) ? CS_PRECH : CS_FINISH;
                    end else begin
                        if (low_cnt == LOW_LIM) begin
                            timing_err <= 1'b1;
                        end else begin
                            low_cnt <= low_cnt + LOW_ONE;
                        end
                        if (!wr_en_n) begin
                            wr_open <= 1'b1;
                            wr_mode <= 1'b1;
                            wr_data <= wdat;
                        end else begin
                            wr_open <= 1'b0;
                        end
                    end
                end
                CS_FINISH: begin
                    if (acc_cnt != ACC_LIM) begin
                        acc_cnt <= acc_cnt + ACC_ONE;
                    end else begin
                        st <= CS_PRECH;
                    end
                    if (pre_cnt != PRE_LIM) begin
                        pre_cnt <= pre_cnt + PRE_ONE;
                    end
                end
                default: st <= CS_IDLE;
            endcase
        end
    end

    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
        (st == CS_ACTIVE && $past(st) == CS_ACTIVE) |-> $stable(lat_addr))
        else $error("captured address moved during a cycle"); // R1

    AST_COMMIT_DATA: assert property (@(posedge clk) disable iff (rst)
        wr_commit |-> (wr_data == $past(wdat)))
        else $error("stored byte is not the last sampled write data"); // R5

    AST_FULL_CYCLE: assert property (@(posedge clk) disable iff (rst)
        (st == CS_PRECH && $past(st) != CS_PRECH) |-> ($past(acc_cnt) == ACC_LIM))
        else $error("precharge entered before the internal cycle completed"); // R7

    AST_PRE_MIN: assert property (@(posedge clk) disable iff (rst)
        (st == CS_ACTIVE && $past(st) == CS_PRECH) |-> ($past(pre_cnt) == PRE_LIM))
        else $error("capture accepted before minimum precharge"); // R7

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        timing_err |=> timing_err)
        else $error("timing error flag dropped without reset"); // R8

    AST_LOW_LIMIT: assert property (@(posedge clk) disable iff (rst)
        (st == CS_ACTIVE && !chip_sel_n && low_cnt == LOW_LIM) |=> timing_err)
        else $error("over-long active time not flagged"); // R9

endmodule

// File: rtl/cel_store.sv
module cel_store #(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 8,
    parameter int DEPTH  = 256
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data
);

    localparam int IDX_W = (DEPTH < 2) ? 1 : $clog2(DEPTH);

    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] mem [DEPTH];

    generate
        if (IDX_W < ADDR_W) begin : g_fold
            logic unused_hi;
            assign idx       = addr[IDX_W-1:0];
            assign unused_hi = ^addr[ADDR_W-1:IDX_W];
        end else begin : g_full
            assign idx = IDX_W'(addr);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[idx] <= wr_data;
        end
    end

    assign rd_data = mem[idx];

endmodule

// File: rtl/cel_drive.sv
module cel_drive
    import cel_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              chip_sel_n,
    input  logic              wr_en_n,
    input  logic              out_en_n,
    input  cyc_flags_t        flags,
    input  logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] rdat,
    output logic              rdat_oe
);

    always_comb begin
        rdat_oe = flags.running && flags.data_ok && !flags.wr_mode
                  && !chip_sel_n && wr_en_n && !out_en_n;
        rdat    = rdat_oe ? rd_data : '0;
    end

endmodule

// File: rtl/cel_bytemem.sv
module cel_bytemem
    import cel_pkg::*;
#(
    parameter int ADDR_W   = 15,
    parameter int DATA_W   = 8,
    parameter int DEPTH    = 256,
    parameter int T_ACC    = 7,
    parameter int T_PRE    = 6,
    parameter int T_MAXACT = 1000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              chip_sel_n,
    input  logic              wr_en_n,
    input  logic              out_en_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] wdat,
    output logic [DATA_W-1:0] rdat,
    output logic              rdat_oe,
    output logic              timing_err
);

    logic [ADDR_W-1:0] lat_addr;
    cyc_flags_t        flags;
    logic              wr_commit;
    logic [DATA_W-1:0] wr_data;
    logic [DATA_W-1:0] rd_data;

    cel_seq #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .T_ACC(T_ACC),
        .T_PRE(T_PRE), .T_MAXACT(T_MAXACT)
    ) u_seq (
        .clk(clk), .rst(rst), .chip_sel_n(chip_sel_n), .wr_en_n(wr_en_n),
        .bus_addr(bus_addr), .wdat(wdat), .lat_addr(lat_addr), .flags(flags),
        .wr_commit(wr_commit), .wr_data(wr_data), .timing_err(timing_err)
    );

    cel_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk(clk), .wr_en(wr_commit), .addr(lat_addr),
        .wr_data(wr_data), .rd_data(rd_data)
    );

    cel_drive #(.DATA_W(DATA_W)) u_drive (
        .chip_sel_n(chip_sel_n), .wr_en_n(wr_en_n), .out_en_n(out_en_n),
        .flags(flags), .rd_data(rd_data), .rdat(rdat), .rdat_oe(rdat_oe)
    );

    AST_WRITE_QUIET: assert property (@(posedge clk) disable iff (rst)
        flags.wr_mode |-> !rdat_oe)
        else $error("bus driven during a write cycle"); // R3

    AST_OE_GATE: assert property (@(posedge clk) disable iff (rst)
        out_en_n |-> !rdat_oe)
        else $error("bus driven with output enable high"); // R6

    AST_DRIVE_LATE: assert property (@(posedge clk) disable iff (rst)
        rdat_oe |-> $past(flags.running))
        else $error("bus driven at the capture edge"); // R6

endmodule

// File: tb/sim_cel_bytemem.sv
module sim_cel_bytemem;

    localparam int ADDR_W   = 15;
    localparam int DATA_W   = 8;
    localparam int DEPTH    = 256;
    localparam int T_ACC    = 7;
    localparam int T_PRE    = 6;
    localparam int T_MAXACT = 40;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              chip_sel_n = 1'b1;
    logic              wr_en_n = 1'b1;
    logic              out_en_n = 1'b1;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [DATA_W-1:0] wdat = '0;
    logic [DATA_W-1:0] rdat;
    logic              rdat_oe;
    logic              timing_err;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic [DATA_W-1:0] ref_mem [DEPTH];
    bit                ref_ok  [DEPTH];

    always #2 clk = ~clk;

    cel_bytemem #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH),
        .T_ACC(T_ACC), .T_PRE(T_PRE), .T_MAXACT(T_MAXACT)
    ) u0 (
        .clk(clk), .rst(rst), .chip_sel_n(chip_sel_n), .wr_en_n(wr_en_n),
        .out_en_n(out_en_n), .bus_addr(bus_addr), .wdat(wdat),
        .rdat(rdat), .rdat_oe(rdat_oe), .timing_err(timing_err)
    );

    function automatic int slot(input logic [ADDR_W-1:0] a);
        return int'(a) % DEPTH;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        chip_sel_n = 1'b1;
        wr_en_n = 1'b1;
        out_en_n = 1'b1;
        step(2);
        rst = 1'b0;
        step(1);
    endtask

    // read cycle; bus_addr switches to a_late one edge after capture
    task automatic do_read(input logic [ADDR_W-1:0] a, input logic [ADDR_W-1:0] a_late,
                           input string tag);
        wr_en_n = 1'b1;
        out_en_n = 1'b0;
        bus_addr = a;
        chip_sel_n = 1'b0;
        step(1);
        bus_addr = a_late;
        step(T_ACC - 1);
        check("R6 no drive before access time", 32'(rdat_oe), 32'd1 - 32'd1);
        step(1);
        check({tag, " read drive"}, 32'(rdat_oe), 32'd1);
        check({tag, " read data"}, 32'(rdat), 32'(ref_mem[slot(a)]));
        chip_sel_n = 1'b1;
        out_en_n = 1'b1;
        step(T_PRE);
    endtask

    // select-timed write: strobe low before the select falls
    task automatic do_write_sel(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        int drove = 0;
        wr_en_n = 1'b0;
        out_en_n = 1'b0;
        wdat = ~d;
        bus_addr = a;
        chip_sel_n = 1'b0;
        for (int i = 0; i < T_ACC; i++) begin
            step(1);
            if (rdat_oe) drove++;
        end
        wdat = d;
        step(1);
        if (rdat_oe) drove++;
        check("R3 bus quiet in select-timed write", 32'(drove), 32'd0);
        chip_sel_n = 1'b1;
        wdat = 8'(~d + 8'd3);
        step(1);
        wr_en_n = 1'b1;
        out_en_n = 1'b1;
        step(T_PRE - 1);
        ref_mem[slot(a)] = d;
        ref_ok[slot(a)] = 1'b1;
    endtask

    // strobe-timed write: starts as a read, strobe falls later
    task automatic do_write_strobe(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        wr_en_n = 1'b1;
        out_en_n = 1'b0;
        bus_addr = a;
        chip_sel_n = 1'b0;
        step(T_ACC + 1);
        check("R4 driven before strobe falls", 32'(rdat_oe), 32'd1);
        if (ref_ok[slot(a)]) check("R4 old data before strobe", 32'(rdat), 32'(ref_mem[slot(a)]));
        wr_en_n = 1'b0;
        wdat = ~d;
        #1;
        check("R4 released when strobe falls", 32'(rdat_oe), 32'd0);
        step(1);
        wdat = d;
        step(1);
        wr_en_n = 1'b1;
        wdat = 8'(d + 8'd1);
        #1;
        check("R4 stays released after strobe rises", 32'(rdat_oe), 32'd0);
        step(1);
        chip_sel_n = 1'b1;
        out_en_n = 1'b1;
        step(T_PRE);
        ref_mem[slot(a)] = d;
        ref_ok[slot(a)] = 1'b1;
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [ADDR_W-1:0] a1, a2;
        logic [DATA_W-1:0] d1, d2;
        int drove;
        void'($urandom(32'h5eed_c0de));
        for (int i = 0; i < DEPTH; i++) ref_ok[i] = 1'b0;
        for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;

        do_reset();
        check("R10 reset error flag", 32'(timing_err), 32'd0);
        check("R2 reset bus undriven", 32'(rdat_oe), 32'd0);
        check("R2 reset data zero", 32'(rdat), 32'd0);

        a1 = 15'h0123; d1 = 8'hA5;
        a2 = 15'h3456; d2 = 8'h3C;
        do_write_sel(a1, d1);
        do_read(a1, a1, "R5 select-timed");
        do_write_strobe(a2, d2);
        do_read(a2, a2, "R5 strobe-timed");

        do_read(a1, a2, "R1 late address ignored");
        do_read(a1 ^ 15'h4000, a1 ^ 15'h4000, "R1 upper bits alias");

        // output enable held high through a complete read
        drove = 0;
        wr_en_n = 1'b1; out_en_n = 1'b1; bus_addr = a1; chip_sel_n = 1'b0;
        for (int i = 0; i < T_ACC + 2; i++) begin
            step(1);
            if (rdat_oe) drove++;
        end
        check("R6 output enable high keeps bus off", 32'(drove), 32'd0);
        check("R2 undriven data is zero", 32'(rdat), 32'd0);
        chip_sel_n = 1'b1;
        step(T_PRE);

        // back-to-back write then read at minimum precharge
        do_write_sel(15'h00FE, 8'h81);
        do_read(15'h00FE, 15'h00FE, "R11 read right after write");
        check("R11 no error at minimum precharge", 32'(timing_err), 32'd0);

        // fall one sample short of precharge
        wr_en_n = 1'b1; out_en_n = 1'b0; bus_addr = a1; chip_sel_n = 1'b0;
        step(T_ACC + 1);
        chip_sel_n = 1'b1;
        step(T_PRE - 1);
        chip_sel_n = 1'b0;
        drove = 0;
        for (int i = 0; i < T_ACC + 2; i++) begin
            step(1);
            if (rdat_oe) drove++;
        end
        check("R8 early fall starts no cycle", 32'(drove), 32'd0);
        check("R8 early fall sets error", 32'(timing_err), 32'd1);
        chip_sel_n = 1'b1; out_en_n = 1'b1;
        step(T_PRE);
        do_read(a2, a2, "R8 later access still works");
        check("R8 error flag sticky", 32'(timing_err), 32'd1);

        do_reset();
        check("R10 reset clears error", 32'(timing_err), 32'd0);
        do_read(a2, a2, "R10 contents kept over reset");

        // early release of the select; refall while the cycle finishes
        wr_en_n = 1'b1; out_en_n = 1'b0; bus_addr = a1; chip_sel_n = 1'b0;
        step(2);
        chip_sel_n = 1'b1;
        step(1);
        check("R7 no error on early release", 32'(timing_err), 32'd0);
        chip_sel_n = 1'b0;
        drove = 0;
        for (int i = 0; i < T_ACC + 1; i++) begin
            step(1);
            if (rdat_oe) drove++;
        end
        check("R7 cycle not restarted while finishing", 32'(drove), 32'd0);
        check("R8 fall during finish flagged", 32'(timing_err), 32'd1);
        chip_sel_n = 1'b1; out_en_n = 1'b1;
        step(T_ACC + T_PRE);
        do_read(a1, a1, "R7 access after completed cycle");

        // maximum active time
        do_reset();
        wr_en_n = 1'b1; out_en_n = 1'b1; bus_addr = a1; chip_sel_n = 1'b0;
        step(T_MAXACT);
        check("R9 no error at limit", 32'(timing_err), 32'd0);
        step(1);
        check("R9 error past limit", 32'(timing_err), 32'd1);
        chip_sel_n = 1'b1;
        step(T_PRE);

        // constrained random mix
        do_reset();
        for (int k = 0; k < 60; k++) begin
            logic [ADDR_W-1:0] ra;
            logic [DATA_W-1:0] rd;
            int kind;
            ra = ADDR_W'($urandom);
            rd = DATA_W'($urandom);
            kind = int'($urandom % 3);
            if (kind == 2 && ref_ok[slot(ra)]) begin
                do_read(ra, ADDR_W'($urandom), "R2 random read");
            end else if (kind == 1) begin
                do_write_strobe(ra, rd);
            end else begin
                do_write_sel(ra, rd);
            end
        end
        check("R7 no error in legal random traffic", 32'(timing_err), 32'd0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule